// File: doc/BRIEF.md
# Program Counter and Return Stack

This block is the instruction address unit of a small microcontroller core. It keeps a 13-bit program counter and an 8-deep return-address stack, and each clock it decides from a set of control strobes what the next program counter is. The strobes are a synchronous restart, interrupt entry, a call or a jump to a supplied target, a return, and a plain advance to the next word. The unit sends the fetch address to program memory. Only a power-of-two region at the bottom of the 8K-word space exists in silicon, and the fetch address is folded into that region by masking.

The strobes are sampled on the rising clock edge. The new fetch address appears right after that edge, with no extra latency. Every input pattern is first reduced to one named operation: `OP_HOLD`, `OP_BOOT`, `OP_VECTOR`, `OP_CALL`, `OP_JUMP`, `OP_RETURN` or `OP_STEP`. A `unique case` over that operation then selects the next counter value. The operation also selects whether the stack pushes, pops or stays idle. The transitions are these:
- Restart goes to `OP_BOOT`.
- Interrupt entry goes to `OP_VECTOR`.
- Each control-transfer strobe goes to its own operation.
- Advance goes to `OP_STEP`.
- No strobe goes to `OP_HOLD`.

The stack is a circular buffer that software cannot see.

Top module: `prog_addr_unit`

## Requirements
- R1: While `rst_n` is low, the program counter, the stack pointer and all stack entries are cleared, so `fetch_addr` reads 0.
- R2: `boot_req` loads program counter 0 at the next edge and leaves the stack untouched.
- R3: `irq_take` loads program counter 4 and pushes the current program counter plus one.
- R4: `call_en` loads `target_addr` and pushes the current program counter plus one.
- R5: `jump_en` loads `target_addr` without touching the stack.
- R6: `ret_en` pops the most recent stack entry into the program counter.
- R7: `step_en` adds one to the program counter, modulo 8192, so 1FFFh is followed by 0.
- R8: With no strobe asserted, the program counter holds its value.
- R9: `fetch_addr` equals the 13-bit program counter ANDed with `IMPL_WORDS-1`. The default `IMPL_WORDS` is 2048. The pushed return address is the unmasked value.
- R10: The stack is circular over 8 entries. A ninth push overwrites the oldest entry. A pop from an empty stack returns whatever the slot holds. No flag is raised in either case.
- R11: Priority in one cycle is `boot_req`, then `irq_take`, then call/jump/return, then `step_en`. Strobes of lower priority have no effect: no load and no push or pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_req | input | 1 | Synchronous restart to address 0 |
| irq_take | input | 1 | Interrupt entry: vector and push |
| step_en | input | 1 | Advance to the next word |
| jump_en | input | 1 | Load target without push |
| call_en | input | 1 | Load target and push return address |
| ret_en | input | 1 | Pop return address into the counter |
| target_addr | input | 13 | Destination for jump and call |
| fetch_addr | output | 13 | Program memory address, folded into the implemented size |

## Verification
A corrupted stack pointer or a bad stack entry stays hidden until a return happens. It then shows up as a wrong `fetch_addr` in the cycle right after `ret_en`. That can be many cycles after the fault, so the checks pair each call with its return, and they also run deep overflow sequences. A priority or wrap error in the counter is visible at `fetch_addr` one edge after the strobe that caused it. A missing or doubled push from a collision between strobes shows only when the later returns come out shifted.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    localparam int PCU_ADDR_W = 13;

    typedef enum logic [2:0] {
        OP_HOLD   = 3'd0,
        OP_BOOT   = 3'd1,
        OP_VECTOR = 3'd2,
        OP_CALL   = 3'd3,
        OP_JUMP   = 3'd4,
        OP_RETURN = 3'd5,
        OP_STEP   = 3'd6
    } pc_op_e;
endpackage

// File: rtl/pcu_op_sel.sv
module pcu_op_sel
    import pcu_pkg::*;
(
    input  logic   boot_req,
    input  logic   irq_take,
    input  logic   step_en,
    input  logic   jump_en,
    input  logic   call_en,
    input  logic   ret_en,
    output pc_op_e op,
    output logic   do_push,
    output logic   do_pop
);
    // Fixed priority: restart, interrupt, transfer, advance
    always_comb begin
        if (boot_req)      op = OP_BOOT;
        else if (irq_take) op = OP_VECTOR;
        else if (call_en)  op = OP_CALL;
        else if (jump_en)  op = OP_JUMP;
        else if (ret_en)   op = OP_RETURN;
        else if (step_en)  op = OP_STEP;
        else               op = OP_HOLD;
    end

    always_comb begin
        do_push = 1'b0;
        do_pop  = 1'b0;
        unique case (op)
            OP_VECTOR, OP_CALL: do_push = 1'b1;
            OP_RETURN:          do_pop  = 1'b1;
            OP_HOLD, OP_BOOT, OP_JUMP, OP_STEP: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
    parameter int WIDTH = 13,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] push_data,
    output logic [WIDTH-1:0] top_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PTR_W-1:0]            wr_ptr;
    logic [PTR_W-1:0]            rd_ptr;
    logic [DEPTH-1:0][WIDTH-1:0] slots;

    assign rd_ptr   = wr_ptr - 1'b1;
    assign top_data = slots[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    wr_ptr <= '0;
        else if (push) wr_ptr <= wr_ptr + 1'b1;
        else if (pop)  wr_ptr <= rd_ptr;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slots[g] <= '0;
            else if (push && wr_ptr == PTR_W'(g))
                slots[g] <= push_data;
        end
    end

    // R10
    push_ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> wr_ptr == PTR_W'($past(wr_ptr) + 1'b1));
    // R6
    pop_ptr_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> wr_ptr == PTR_W'($past(wr_ptr) - 1'b1));
    // R11
    push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
endmodule

// File: rtl/prog_addr_unit.sv
module prog_addr_unit
    import pcu_pkg::*;
#(
    parameter int PC_W        = PCU_ADDR_W,
    parameter int STACK_DEPTH = 8,
    parameter int IMPL_WORDS  = 2048,
    parameter int BOOT_VECTOR = 0,
    parameter int IRQ_VECTOR  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            boot_req,
    input  logic            irq_take,
    input  logic            step_en,
    input  logic            jump_en,
    input  logic            call_en,
    input  logic            ret_en,
    input  logic [PC_W-1:0] target_addr,
    output logic [PC_W-1:0] fetch_addr
);
    localparam logic [PC_W-1:0] WRAP_MASK = PC_W'(IMPL_WORDS - 1);
    localparam logic [PC_W-1:0] BOOT_PC   = PC_W'(BOOT_VECTOR);
    localparam logic [PC_W-1:0] IRQ_PC    = PC_W'(IRQ_VECTOR);

    pc_op_e          op;
    logic            do_push;
    logic            do_pop;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;
    logic [PC_W-1:0] pc_inc;
    logic [PC_W-1:0] stack_top;

    pcu_op_sel u_sel (
        .boot_req (boot_req),
        .irq_take (irq_take),
        .step_en  (step_en),
        .jump_en  (jump_en),
        .call_en  (call_en),
        .ret_en   (ret_en),
        .op       (op),
        .do_push  (do_push),
        .do_pop   (do_pop)
    );

    assign pc_inc = pc_q + 1'b1;

    pcu_ret_stack #(
        .WIDTH (PC_W),
        .DEPTH (STACK_DEPTH)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .pop       (do_pop),
        .push_data (pc_inc),
        .top_data  (stack_top)
    );

    // Next-counter selection
    always_comb begin
        unique case (op)
            OP_BOOT:   pc_d = BOOT_PC;
            OP_VECTOR: pc_d = IRQ_PC;
            OP_CALL:   pc_d = target_addr;
            OP_JUMP:   pc_d = target_addr;
            OP_RETURN: pc_d = stack_top;
            OP_STEP:   pc_d = pc_inc;
            OP_HOLD:   pc_d = pc_q;
            default:   pc_d = pc_q;
        endcase
    end

    // Counter register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    // Output fold into the implemented region
    always_comb fetch_addr = pc_q & WRAP_MASK;

    // R2
    boot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_req |=> fetch_addr == (BOOT_PC & WRAP_MASK));
    // R3
    irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && !boot_req) |=> fetch_addr == (IRQ_PC & WRAP_MASK));
    // R5
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_en && !boot_req && !irq_take && !call_en) |=>
            fetch_addr == ($past(target_addr) & WRAP_MASK));
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(boot_req || irq_take || step_en || jump_en || call_en || ret_en)
            |=> $stable(fetch_addr));
    // R9
    fold_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, fetch_addr} < (PC_W+1)'(IMPL_WORDS));
endmodule

// File: tb/prog_addr_unit_tb_top.sv
module prog_addr_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MASK = 2047;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_req = 1'b0, irq_take = 1'b0, step_en = 1'b0;
    logic        jump_en = 1'b0, call_en = 1'b0, ret_en = 1'b0;
    logic [12:0] target_addr = '0;
    logic [12:0] fetch_addr;

    int checks = 0;
    int errors = 0;
    logic [12:0] exp_q[$];
    string       tag_q[$];

    logic [12:0] m_pc = '0;
    logic [12:0] m_stk [8];
    int          m_sp = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_addr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .boot_req(boot_req), .irq_take(irq_take),
        .step_en(step_en), .jump_en(jump_en), .call_en(call_en),
        .ret_en(ret_en), .target_addr(target_addr), .fetch_addr(fetch_addr)
    );

    task automatic compare(input logic [12:0] exp, input string tag);
        checks++;
        if (fetch_addr !== exp) begin
            errors++;
            $display("FAIL %s: fetch_addr actual %h expected %h", tag, fetch_addr, exp);
        end
    endtask

    task automatic m_push(input logic [12:0] v);
        m_stk[m_sp] = v;
        m_sp = (m_sp + 1) % 8;
    endtask

    // Driver: applies one cycle of strobes and queues the expected address
    task automatic cycle(input logic bt, input logic ir, input logic st,
                         input logic jp, input logic cl, input logic rt,
                         input logic [12:0] tgt, input string tag);
        @(negedge clk);
        boot_req = bt; irq_take = ir; step_en = st;
        jump_en = jp; call_en = cl; ret_en = rt; target_addr = tgt;
        if (bt)      m_pc = 13'h0000;
        else if (ir) begin m_push(m_pc + 13'd1); m_pc = 13'h0004; end
        else if (cl) begin m_push(m_pc + 13'd1); m_pc = tgt; end
        else if (jp) m_pc = tgt;
        else if (rt) begin m_sp = (m_sp + 7) % 8; m_pc = m_stk[m_sp]; end
        else if (st) m_pc = m_pc + 13'd1;
        exp_q.push_back(m_pc & 13'(MASK));
        tag_q.push_back(tag);
    endtask

    // Monitor: compares one queued item per clock, after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
        repeat (3) @(posedge clk);
        #2 compare(13'h0000, "R1 reset value");
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < 3; i++) cycle(0,0,1,0,0,0,'0, "R7 step");
        cycle(0,0,0,0,0,0,13'h1555, "R8 idle hold");
        cycle(0,0,0,1,0,0,13'h0123, "R5 jump");
        cycle(0,0,0,0,1,0,13'h0900, "R4 R9 call folded");
        cycle(0,0,1,0,0,0,'0, "R9 step folded");
        cycle(0,0,0,0,1,0,13'h1FFF, "R4 call top");
        cycle(0,0,1,0,0,0,'0, "R7 wrap 1FFF to 0");
        cycle(0,0,0,0,0,1,'0, "R6 R9 return unmasked");
        cycle(0,0,0,0,0,1,'0, "R6 return nested");
        cycle(0,1,0,0,0,0,'0, "R3 irq vector");
        cycle(0,1,0,0,1,0,13'h0333, "R11 irq over call");
        cycle(1,1,1,0,0,0,'0, "R2 R11 boot first");
        cycle(0,0,0,0,0,1,'0, "R11 single push on irq+call");
        cycle(0,0,0,0,0,1,'0, "R3 R2 irq return, stack kept");
        cycle(0,0,1,1,0,0,13'h0040, "R11 jump over step");
        cycle(0,0,1,0,0,1,'0, "R11 return over step");

        for (int i = 0; i < 9; i++)
            cycle(0,0,0,0,1,0,13'(13'h0200 + 13'(i*3)), "R10 overflow push");
        for (int i = 0; i < 10; i++)
            cycle(0,0,0,0,0,1,'0, "R10 pops after overflow");

        cycle(0,0,1,0,0,0,'0, "R7 step before reset");
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b0;
        #1 compare(13'h0000, "R1 async reset");
        m_pc = '0; m_sp = 0;
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
        @(negedge clk) rst_n = 1'b1;
        cycle(0,0,0,0,0,1,'0, "R1 R10 pop after reset");

        repeat (3) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule